// File: doc/BRIEF.md
# Instruction Cycle Control Sequencer

This block is the hardwired control unit of a small single-accumulator processor. It keeps track of which subcycle of the instruction cycle the processor is in (fetch, indirect, execute or interrupt) and which of three timing steps inside that subcycle is current. In every clock it raises the set of control strobes belonging to that step. These strobes open the register transfer paths among the program counter, memory address register, memory buffer register, instruction register and accumulator, and they drive the memory read and write commands.

The datapath, memory and ALU sit outside. They give the sequencer the opcode and indirect bit of the current instruction, an interrupt request with its enable, and the ALU zero flag. During the last fetch step, the datapath presents the indirect bit of the word being loaded into the instruction register. Three opcodes have execute sequences: add-to-accumulator, store-accumulator and increment-and-skip-if-zero. Every other opcode executes as three idle steps.

Top module: `icycle_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the following cycle shows `cycle_code` 00, `step_idx` 0 (T1) and every strobe low. The first cycle after the first edge with `rst_n` high is fetch T1.
- R2: `cycle_code` encodes fetch 00, indirect 01, execute 10 and interrupt 11. `step_idx` counts 0, 1, 2 for T1, T2, T3. Each subcycle lasts exactly three clocks, and the code changes only after T3.
- R3: Fetch raises `c_pc_to_mar` in T1, then `c_mem_rd` together with `c_pc_inc` in T2, then `c_mbr_to_ir` in T3.
- R4: After fetch T3, the next subcycle is indirect (01) if `ir_indirect` was high during T3, and execute (10) if it was low.
- R5: Indirect raises `c_iradr_to_mar` in T1, then `c_mem_rd` in T2, then `c_mbradr_to_iradr` in T3, and is always followed by execute.
- R6: Execute with opcode 1 (add) raises `c_iradr_to_mar` in T1, then `c_mem_rd` in T2, then `c_ac_add` in T3.
- R7: Execute with opcode 2 (store) raises `c_iradr_to_mar` in T1, then `c_ac_to_mbr` in T2, then `c_mem_wr` in T3.
- R8: Execute with opcode 3 (increment-and-skip-if-zero) raises `c_iradr_to_mar` in T1 and `c_mem_rd` in T2. In T3 it raises `c_pc_inc` exactly when `flag_zero` is high.
- R9: Execute with any other opcode runs its three steps with every strobe low.
- R10: After execute T3, the next subcycle is interrupt (11) only if both `irq_pending` and `irq_enable` were high during T3. Otherwise it is fetch (00). A pending request outside execute T3 has no effect.
- R11: Interrupt raises `c_pc_to_mbr` in T1, then `c_save_to_mar` together with `c_vec_to_pc` in T2, then `c_mem_wr` in T3, and is always followed by fetch.
- R12: In each clock only the strobes listed for the current step are high. `c_mem_rd` and `c_mem_wr` are never high together, and at most one source drives the memory address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_opcode | input | OP_W | Opcode field of the instruction register |
| ir_indirect | input | 1 | Indirect-address bit of the instruction (valid in fetch T3) |
| irq_pending | input | 1 | Interrupt request pending |
| irq_enable | input | 1 | Interrupts enabled |
| flag_zero | input | 1 | ALU zero flag |
| cycle_code | output | 2 | Current subcycle code |
| step_idx | output | 2 | Current timing step, 0 to 2 |
| c_pc_to_mar | output | 1 | Program counter to address register |
| c_mem_rd | output | 1 | Memory read into buffer register |
| c_pc_inc | output | 1 | Program counter increment |
| c_mbr_to_ir | output | 1 | Buffer register to instruction register |
| c_iradr_to_mar | output | 1 | Instruction address field to address register |
| c_mbradr_to_iradr | output | 1 | Buffer address field to instruction address field |
| c_pc_to_mbr | output | 1 | Program counter to buffer register |
| c_save_to_mar | output | 1 | Fixed save address to address register |
| c_vec_to_pc | output | 1 | Fixed service-routine address to program counter |
| c_mem_wr | output | 1 | Memory write from buffer register |
| c_ac_add | output | 1 | Accumulator gets accumulator plus buffer register |
| c_ac_to_mbr | output | 1 | Accumulator to buffer register |

## Verification
A wrong subcycle code or step count shows at `cycle_code` and `step_idx` in the same clock. It also shows in the strobe pattern, which departs from the expected one at the first step after the fault. A wrong transition decision is therefore visible one clock after T3, where the first step of the wrong subcycle raises the wrong strobe. The bench sweeps every opcode against every combination of indirect bit, interrupt request, interrupt enable and zero flag. It compares the complete strobe vector and the phase outputs in every clock, so a stray or missing strobe is reported in the step where it occurs.

// File: rtl/icyc_pkg.sv
`timescale 1ns/1ps
// Shared types for the instruction cycle sequencer.
// Assumes a fixed three-step subcycle and a 2-bit subcycle code.
package icyc_pkg;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_INDIR = 2'b01,
        CYC_EXEC  = 2'b10,
        CYC_INTR  = 2'b11
    } cyc_e;

    localparam int NUM_STEPS = 3;
    localparam int STEP_W    = $clog2(NUM_STEPS + 1);

    typedef struct packed {
        logic pc_to_mar;
        logic mem_rd;
        logic pc_inc;
        logic mbr_to_ir;
        logic iradr_to_mar;
        logic mbradr_to_iradr;
        logic pc_to_mbr;
        logic save_to_mar;
        logic vec_to_pc;
        logic mem_wr;
        logic ac_add;
        logic ac_to_mbr;
    } strobe_t;

endpackage

// File: rtl/icyc_step_timer.sv
`timescale 1ns/1ps
// Timing-step counter: T1..T3 within a subcycle, wraps to T1 after T3.
// Assumes synchronous active-low reset; 'live' rises one clock after
// reset release and gates all strobes until then.
module icyc_step_timer
    import icyc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic              live,
    output logic [STEP_W-1:0] step,
    output logic              step_last
);

    localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_STEPS - 1);

    assign step_last = (step == LAST);

    // Advance the step once running; hold T1 in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= 1'b0;
            step <= '0;
        end else begin
            live <= 1'b1;
            if (live) begin
                step <= step_last ? '0 : step + 1'b1;
            end
        end
    end

    AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step <= LAST);                                          // R2
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (live && step_last) |=> (step == '0));                  // R2

endmodule

// File: rtl/icyc_cycle_reg.sv
`timescale 1ns/1ps
// Subcycle code register and its transition rules.
// Assumes 'advance' is high only in the last step of a subcycle.
module icyc_cycle_reg
    import icyc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic ir_indirect,
    input  logic irq_take,
    output cyc_e cyc
);

    cyc_e cyc_nx;

    // Choose the subcycle that follows the current one.
    always_comb begin
        unique case (cyc)
            CYC_FETCH: cyc_nx = ir_indirect ? CYC_INDIR : CYC_EXEC;
            CYC_INDIR: cyc_nx = CYC_EXEC;
            CYC_EXEC:  cyc_nx = irq_take ? CYC_INTR : CYC_FETCH;
            CYC_INTR:  cyc_nx = CYC_FETCH;
            default:   cyc_nx = CYC_FETCH;
        endcase
    end

    // Register the subcycle code; change only at the end of a subcycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= CYC_FETCH;
        end else if (advance) begin
            cyc <= cyc_nx;
        end
    end

    AST_HOLD_MID: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(cyc));                             // R2
    AST_FETCH_IND: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && cyc == CYC_FETCH && ir_indirect) |=> (cyc == CYC_INDIR)); // R4
    AST_IND_TO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && cyc == CYC_INDIR) |=> (cyc == CYC_EXEC));   // R5
    AST_EXEC_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && cyc == CYC_EXEC && !irq_take) |=> (cyc == CYC_FETCH)); // R10
    AST_INT_TO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && cyc == CYC_INTR) |=> (cyc == CYC_FETCH));   // R11

endmodule

// File: rtl/icyc_strobe_dec.sv
`timescale 1ns/1ps
// Decodes subcycle, step, opcode and zero flag into control strobes.
// Assumes opcode and flag are stable during the execute steps.
module icyc_strobe_dec
    import icyc_pkg::*;
#(
    parameter int             OP_W     = 3,
    parameter logic [OP_W-1:0] OP_ADD   = 1,
    parameter logic [OP_W-1:0] OP_STORE = 2,
    parameter logic [OP_W-1:0] OP_ISZ   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              live,
    input  cyc_e              cyc,
    input  logic [STEP_W-1:0] step,
    input  logic [OP_W-1:0]   opcode,
    input  logic              flag_zero,
    output strobe_t           s
);

    localparam logic [STEP_W-1:0] T1 = STEP_W'(0);
    localparam logic [STEP_W-1:0] T2 = STEP_W'(1);
    localparam logic [STEP_W-1:0] T3 = STEP_W'(2);

    // One strobe set per clock, selected by subcycle and step.
    always_comb begin
        s = '0;
        if (live) begin
            unique case (cyc)
                CYC_FETCH: begin
                    if (step == T1) s.pc_to_mar = 1'b1;
                    if (step == T2) begin
                        s.mem_rd = 1'b1;
                        s.pc_inc = 1'b1;
                    end
                    if (step == T3) s.mbr_to_ir = 1'b1;
                end
                CYC_INDIR: begin
                    if (step == T1) s.iradr_to_mar    = 1'b1;
                    if (step == T2) s.mem_rd          = 1'b1;
                    if (step == T3) s.mbradr_to_iradr = 1'b1;
                end
                CYC_EXEC: begin
                    if (opcode == OP_ADD) begin
                        if (step == T1) s.iradr_to_mar = 1'b1;
                        if (step == T2) s.mem_rd       = 1'b1;
                        if (step == T3) s.ac_add       = 1'b1;
                    end else if (opcode == OP_STORE) begin
                        if (step == T1) s.iradr_to_mar = 1'b1;
                        if (step == T2) s.ac_to_mbr    = 1'b1;
                        if (step == T3) s.mem_wr       = 1'b1;
                    end else if (opcode == OP_ISZ) begin
                        if (step == T1) s.iradr_to_mar = 1'b1;
                        if (step == T2) s.mem_rd       = 1'b1;
                        if (step == T3) s.pc_inc       = flag_zero;
                    end
                end
                CYC_INTR: begin
                    if (step == T1) s.pc_to_mbr = 1'b1;
                    if (step == T2) begin
                        s.save_to_mar = 1'b1;
                        s.vec_to_pc   = 1'b1;
                    end
                    if (step == T3) s.mem_wr = 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(s.mem_rd && s.mem_wr));                               // R12
    AST_MAR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s.pc_to_mar, s.iradr_to_mar, s.save_to_mar})); // R12

endmodule

// File: rtl/icycle_sequencer.sv
`timescale 1ns/1ps
// Hardwired instruction cycle sequencer for a single-accumulator core.
// Steps fetch/indirect/execute/interrupt subcycles of three steps each
// and emits the register-transfer and memory strobes for every step.
// Assumes the datapath presents the fetched indirect bit in fetch T3.
module icycle_sequencer
    import icyc_pkg::*;
#(
    parameter int             OP_W     = 3,
    parameter logic [OP_W-1:0] OP_ADD   = 1,
    parameter logic [OP_W-1:0] OP_STORE = 2,
    parameter logic [OP_W-1:0] OP_ISZ   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] ir_opcode,
    input  logic            ir_indirect,
    input  logic            irq_pending,
    input  logic            irq_enable,
    input  logic            flag_zero,
    output logic [1:0]      cycle_code,
    output logic [1:0]      step_idx,
    output logic            c_pc_to_mar,
    output logic            c_mem_rd,
    output logic            c_pc_inc,
    output logic            c_mbr_to_ir,
    output logic            c_iradr_to_mar,
    output logic            c_mbradr_to_iradr,
    output logic            c_pc_to_mbr,
    output logic            c_save_to_mar,
    output logic            c_vec_to_pc,
    output logic            c_mem_wr,
    output logic            c_ac_add,
    output logic            c_ac_to_mbr
);

    logic              live;
    logic [STEP_W-1:0] step;
    logic              step_last;
    cyc_e              cyc;
    strobe_t           s;

    icyc_step_timer u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (live),
        .step      (step),
        .step_last (step_last)
    );

    icyc_cycle_reg u_cycle (
        .clk         (clk),
        .rst_n       (rst_n),
        .advance     (live && step_last),
        .ir_indirect (ir_indirect),
        .irq_take    (irq_pending && irq_enable),
        .cyc         (cyc)
    );

    icyc_strobe_dec #(
        .OP_W     (OP_W),
        .OP_ADD   (OP_ADD),
        .OP_STORE (OP_STORE),
        .OP_ISZ   (OP_ISZ)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (live),
        .cyc       (cyc),
        .step      (step),
        .opcode    (ir_opcode),
        .flag_zero (flag_zero),
        .s         (s)
    );

    assign cycle_code        = cyc;
    assign step_idx          = 2'(step);
    assign c_pc_to_mar       = s.pc_to_mar;
    assign c_mem_rd          = s.mem_rd;
    assign c_pc_inc          = s.pc_inc;
    assign c_mbr_to_ir       = s.mbr_to_ir;
    assign c_iradr_to_mar    = s.iradr_to_mar;
    assign c_mbradr_to_iradr = s.mbradr_to_iradr;
    assign c_pc_to_mbr       = s.pc_to_mbr;
    assign c_save_to_mar     = s.save_to_mar;
    assign c_vec_to_pc       = s.vec_to_pc;
    assign c_mem_wr          = s.mem_wr;
    assign c_ac_add          = s.ac_add;
    assign c_ac_to_mbr       = s.ac_to_mbr;

    AST_INT_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_INTR && step == '0) |-> ($past(cyc) == CYC_EXEC)); // R10

endmodule

// File: tb/icycle_sequencer_bench.sv
`timescale 1ns/1ps
// Sweeps all opcodes against indirect, interrupt and zero-flag inputs
// and compares every clock's phase and strobe vector to expectations.
module icycle_sequencer_bench;

    localparam int OP_W = 3;
    // Bit positions of the observed strobe vector.
    localparam int B_PC_MAR = 11, B_RD = 10, B_PCINC = 9, B_MBR_IR = 8;
    localparam int B_IRA_MAR = 7, B_MBRA_IRA = 6, B_PC_MBR = 5, B_SAVE = 4;
    localparam int B_VEC = 3, B_WR = 2, B_ADD = 1, B_AC_MBR = 0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [OP_W-1:0] ir_opcode = '0;
    logic ir_indirect = 1'b0, irq_pending = 1'b0, irq_enable = 1'b0, flag_zero = 1'b0;
    logic [1:0] cycle_code, step_idx;
    logic c_pc_to_mar, c_mem_rd, c_pc_inc, c_mbr_to_ir, c_iradr_to_mar;
    logic c_mbradr_to_iradr, c_pc_to_mbr, c_save_to_mar, c_vec_to_pc;
    logic c_mem_wr, c_ac_add, c_ac_to_mbr;
    logic [11:0] obs;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    icycle_sequencer u_icycle_sequencer (
        .clk(clk), .rst_n(rst_n), .ir_opcode(ir_opcode), .ir_indirect(ir_indirect),
        .irq_pending(irq_pending), .irq_enable(irq_enable), .flag_zero(flag_zero),
        .cycle_code(cycle_code), .step_idx(step_idx),
        .c_pc_to_mar(c_pc_to_mar), .c_mem_rd(c_mem_rd), .c_pc_inc(c_pc_inc),
        .c_mbr_to_ir(c_mbr_to_ir), .c_iradr_to_mar(c_iradr_to_mar),
        .c_mbradr_to_iradr(c_mbradr_to_iradr), .c_pc_to_mbr(c_pc_to_mbr),
        .c_save_to_mar(c_save_to_mar), .c_vec_to_pc(c_vec_to_pc),
        .c_mem_wr(c_mem_wr), .c_ac_add(c_ac_add), .c_ac_to_mbr(c_ac_to_mbr)
    );

    assign obs = {c_pc_to_mar, c_mem_rd, c_pc_inc, c_mbr_to_ir, c_iradr_to_mar,
                  c_mbradr_to_iradr, c_pc_to_mbr, c_save_to_mar, c_vec_to_pc,
                  c_mem_wr, c_ac_add, c_ac_to_mbr};

    // Expected strobes for a subcycle/step, from the requirement text.
    function automatic logic [11:0] exp_strobes(int cyc, int st, int op, bit z);
        logic [11:0] v = '0;
        case (cyc)
            0: begin // R3
                if (st == 0) v[B_PC_MAR] = 1'b1;
                if (st == 1) begin v[B_RD] = 1'b1; v[B_PCINC] = 1'b1; end
                if (st == 2) v[B_MBR_IR] = 1'b1;
            end
            1: begin // R5
                if (st == 0) v[B_IRA_MAR] = 1'b1;
                if (st == 1) v[B_RD] = 1'b1;
                if (st == 2) v[B_MBRA_IRA] = 1'b1;
            end
            2: begin // R6 R7 R8 R9
                if (op == 1 || op == 2 || op == 3) begin
                    if (st == 0) v[B_IRA_MAR] = 1'b1;
                end
                if (op == 1) begin
                    if (st == 1) v[B_RD] = 1'b1;
                    if (st == 2) v[B_ADD] = 1'b1;
                end
                if (op == 2) begin
                    if (st == 1) v[B_AC_MBR] = 1'b1;
                    if (st == 2) v[B_WR] = 1'b1;
                end
                if (op == 3) begin
                    if (st == 1) v[B_RD] = 1'b1;
                    if (st == 2) v[B_PCINC] = z;
                end
            end
            default: begin // R11
                if (st == 0) v[B_PC_MBR] = 1'b1;
                if (st == 1) begin v[B_SAVE] = 1'b1; v[B_VEC] = 1'b1; end
                if (st == 2) v[B_WR] = 1'b1;
            end
        endcase
        return v;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic string strobe_tag(int cyc, int op);
        if (cyc == 0) return "R3";
        if (cyc == 1) return "R5";
        if (cyc == 3) return "R11";
        if (op == 1) return "R6";
        if (op == 2) return "R7";
        if (op == 3) return "R8";
        return "R9";
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int exp_cyc = 0;
        int exp_step = 0;
        string ph_tag = "R1";
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset strobes", int'(obs), 0);
        check("R1", "reset cycle_code", int'(cycle_code), 0);
        check("R1", "reset step", int'(step_idx), 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);

        for (int op = 0; op < 8; op++) begin
            for (int ind = 0; ind < 2; ind++) begin
                for (int irq = 0; irq < 4; irq++) begin
                    for (int z = 0; z < 2; z++) begin
                        bit done = 1'b0;
                        ir_opcode   = OP_W'(op);
                        ir_indirect = ind[0];
                        irq_pending = irq[1];
                        irq_enable  = irq[0];
                        flag_zero   = z[0];
                        while (!done) begin
                            check(ph_tag, "cycle_code", int'(cycle_code), exp_cyc);
                            check("R2", "step_idx", int'(step_idx), exp_step);
                            check(strobe_tag(exp_cyc, op), "strobes", int'(obs),
                                  int'(exp_strobes(exp_cyc, exp_step, op, z[0])));
                            check("R12", "rd/wr overlap", int'(c_mem_rd & c_mem_wr), 0);
                            if (exp_step < 2) begin
                                exp_step++;
                                ph_tag = "R2";
                            end else begin
                                exp_step = 0;
                                case (exp_cyc)
                                    0: begin exp_cyc = ind ? 1 : 2; ph_tag = "R4"; end
                                    1: begin exp_cyc = 2; ph_tag = "R5"; end
                                    2: begin exp_cyc = (irq == 3) ? 3 : 0; ph_tag = "R10"; end
                                    default: begin exp_cyc = 0; ph_tag = "R11"; end
                                endcase
                                if (exp_cyc == 0) done = 1'b1;
                            end
                            @(posedge clk); @(negedge clk);
                        end
                    end
                end
            end
        end

        // R10: a request raised outside execute T3 does not divert fetch.
        ir_opcode = OP_W'(1); ir_indirect = 1'b0;
        irq_pending = 1'b1; irq_enable = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        irq_pending = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R10", "early irq ignored, cycle", int'(cycle_code), 2);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        check("R10", "fetch after exec, cycle", int'(cycle_code), 0);

        // R1: reset in the middle of a subcycle.
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1", "mid reset strobes", int'(obs), 0);
        check("R1", "mid reset cycle_code", int'(cycle_code), 0);
        check("R1", "mid reset step", int'(step_idx), 0);
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", "first step after reset", int'(obs), 1 << B_PC_MAR);
        check("R1", "first cycle_code", int'(cycle_code), 0);

        summary();
    end

endmodule